// File: doc/BRIEF.md
# MSI Event Queue Writer

This block accepts message-signalled interrupt writes that have already been decoded from the PCIe transaction layer. Each write carries a requester ID, a 64-bit address, 32 bits of data and a flag for 32-bit or 64-bit addressing. The low 16 bits of the data select an MSI number. The block looks that number up in a mapping table. If the MSI may proceed, the block formats a two-word record and writes it into the tail slot of one of several ring-buffer event queues. The records leave on a write port that carries the queue index and the slot index. The backing memory lives outside the block.

Software works through a small register port. Through it, software programs the MSI-to-queue map, enables and disables queues, acknowledges pending MSIs, clears overflow and moves head pointers forward. Each queue drives one non-empty output, which replaces interrupt delivery. An MSI that has been accepted blocks any further records for the same number until software clears its pending latch.

Top module: `msi_eq_writer`

## Requirements
- R1: After reset every queue reads state 1 (idle), head 0 and tail 0 with the overflow flag clear, every map entry reads zero, all non-empty outputs are low, and no queue write is issued.
- R2: A write with select 0 (map) sets the valid bit from wdata bit 63 and the target queue from wdata bits 5:0. Reading select 0 returns valid at bit 63, pending at bit 62 and the queue at bits 5:0. An MSI is dropped with no queue write when its entry is not valid, its number is NUM_MSI or more, or its target queue is NUM_EQ or more.
- R3: An accepted MSI sets that entry's pending bit. Later MSIs with the same number are dropped while the bit is set. A write with select 1 (MSI clear) and wdata bit 62 set clears the bit.
- R4: The state register (select 4) reads idle = 1, active = 2 or error = 4. A write with select 2 and bit 44 set moves an idle queue to active. A write with select 3 and bit 44 set returns the queue to idle. An MSI whose target queue is not active is dropped.
- R5: Record word 0 holds 0 at bit 63 and the format/type at bits 62:56: 0x58 for a 32-bit MSI and 0x78 for a 64-bit MSI, so type = format/type >> 3 is 0xb or 0xf. It also holds length 1 at bits 55:46, address bits 15:2 at 45:32, the requester ID at 31:16 and data bits 15:0 at 15:0.
- R6: Record word 1 holds address bits 63:16 at bits 63:16 and data bits 31:16 at bits 15:0.
- R7: An accepted MSI produces exactly one write, one cycle after it is presented. That write names the target queue and a slot equal to the queue's tail before the MSI. The tail then advances by one and wraps from EQ_ENTRIES-1 to 0. The tail reads through select 5 at bits 6:0.
- R8: When the advanced tail would equal the head, no write is made and the tail does not move. The overflow flag (select 5, bit 57) is set and the queue enters error. A write with select 3 and bit 57 set clears overflow and returns an errored queue to idle.
- R9: The head reads and writes through select 6 at bits 6:0. A queue's non-empty output is high exactly when the queue is active and its head differs from its tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msi_valid_i | input | 1 | Decoded MSI write present this cycle |
| msi_is64_i | input | 1 | MSI used a 64-bit address |
| msi_rid_i | input | 16 | Requester ID |
| msi_addr_i | input | 64 | MSI address |
| msi_data_i | input | 32 | MSI data; bits 15:0 give the MSI number |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select: 0 map, 1 MSI clear, 2 control set, 3 control clear, 4 state, 5 tail, 6 head |
| reg_idx_i | input | IDX_W | MSI number or queue number |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for the current select and index (combinational) |
| eq_wr_valid_o | output | 1 | Queue record write |
| eq_wr_queue_o | output | EQ_W | Queue index of the write |
| eq_wr_slot_o | output | 7 | Slot index of the write |
| eq_wr_word0_o | output | 64 | Record word 0 |
| eq_wr_word1_o | output | 64 | Record word 1 |
| eq_nonempty_o | output | NUM_EQ | Per-queue non-empty indication |

## Verification
The queue write comes from one register stage. It therefore appears on the port during the cycle after the edge that samples the MSI. Tail, pending, overflow and state change at that same edge. Register reads are combinational.

The bench drives on falling edges and the scoreboard samples on every falling edge. An expected record is pushed before the capturing rising edge, so it is always queued when the record arrives. A record that is missing or extra is caught both by a record arriving with nothing queued and by the queue having to be empty at the end. Register and non-empty checks are sampled at a falling edge after the write strobe has been removed.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'b001,
    ST_ACTIVE = 3'b010,
    ST_ERROR  = 3'b100
  } eq_state_e;

  typedef enum logic [2:0] {
    RS_MAP    = 3'd0,
    RS_MSICLR = 3'd1,
    RS_CSET   = 3'd2,
    RS_CCLR   = 3'd3,
    RS_STATE  = 3'd4,
    RS_TAIL   = 3'd5,
    RS_HEAD   = 3'd6
  } reg_sel_e;

  localparam int BIT_VALID = 63;
  localparam int BIT_PEND  = 62;
  localparam int BIT_OFLOW = 57;
  localparam int BIT_EN    = 44;
  localparam int PTR_W     = 7;
  localparam int QNUM_W    = 6;

  localparam logic [6:0] FT_MSI32 = 7'h58;
  localparam logic [6:0] FT_MSI64 = 7'h78;

  typedef struct packed {
    logic              valid;
    logic              pend;
    logic [QNUM_W-1:0] eq;
  } map_ent_t;

  function automatic logic [63:0] mk_word0(input logic is64, input logic [15:0] rid,
                                           input logic [63:0] addr, input logic [31:0] data);
    return {1'b0, (is64 ? FT_MSI64 : FT_MSI32), 10'd1, addr[15:2], rid, data[15:0]};
  endfunction

  function automatic logic [63:0] mk_word1(input logic [63:0] addr, input logic [31:0] data);
    return {addr[63:16], data[31:16]};
  endfunction
endpackage

// File: rtl/msi_map_table.sv
module msi_map_table
  import msi_eq_pkg::*;
#(
  parameter int NUM_MSI = 32,
  localparam int MSI_W = (NUM_MSI > 1) ? $clog2(NUM_MSI) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_pend_i,
  input  logic [MSI_W-1:0]  set_idx_i,
  input  logic              cfg_we_i,
  input  logic [MSI_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic [QNUM_W-1:0] cfg_eq_i,
  input  logic              clr_we_i,
  input  logic [MSI_W-1:0]  clr_idx_i,
  output map_ent_t          ents_o [NUM_MSI]
);
  map_ent_t ents_q [NUM_MSI];

  for (genvar i = 0; i < NUM_MSI; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ents_q[i] <= '0;
      end else begin
        if (cfg_we_i && cfg_idx_i == MSI_W'(i)) begin
          ents_q[i].valid <= cfg_valid_i;
          ents_q[i].eq    <= cfg_eq_i;
        end
        if (set_pend_i && set_idx_i == MSI_W'(i)) ents_q[i].pend <= 1'b1;
        // software clear wins over a same-cycle set
        if (clr_we_i && clr_idx_i == MSI_W'(i)) ents_q[i].pend <= 1'b0;
      end
    end
    assign ents_o[i] = ents_q[i];

    // R3
    pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_pend_i && set_idx_i == MSI_W'(i) && !(clr_we_i && clr_idx_i == MSI_W'(i)))
        |=> ents_q[i].pend);
    // R3
    pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && clr_idx_i == MSI_W'(i)) |=> !ents_q[i].pend);
  end
endmodule

// File: rtl/msi_eq_queue.sv
module msi_eq_queue
  import msi_eq_pkg::*;
#(
  parameter int EQ_ENTRIES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             set_en_i,
  input  logic             dis_i,
  input  logic             clr_of_i,
  input  logic             head_we_i,
  input  logic [PTR_W-1:0] head_i,
  output logic             wr_ok_o,
  output eq_state_e        state_o,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             oflow_o,
  output logic             nonempty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(EQ_ENTRIES - 1);

  eq_state_e        state_q;
  logic [PTR_W-1:0] head_q, tail_q, tail_nxt;
  logic             oflow_q, active, full;

  assign active   = (state_q == ST_ACTIVE);
  assign tail_nxt = (tail_q == LAST) ? '0 : tail_q + PTR_W'(1);
  assign full     = (tail_nxt == head_q);
  assign wr_ok_o  = push_i && active && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      head_q  <= '0;
      tail_q  <= '0;
      oflow_q <= 1'b0;
    end else begin
      if (push_i && active) begin
        if (full) begin
          oflow_q <= 1'b1;
          state_q <= ST_ERROR;
        end else begin
          tail_q <= tail_nxt;
        end
      end
      if (set_en_i && state_q == ST_IDLE) state_q <= ST_ACTIVE;
      if (dis_i) state_q <= ST_IDLE;
      if (clr_of_i) begin
        oflow_q <= 1'b0;
        if (state_q == ST_ERROR) state_q <= ST_IDLE;
      end
      if (head_we_i) head_q <= head_i;
    end
  end

  assign state_o    = state_q;
  assign head_o     = head_q;
  assign tail_o     = tail_q;
  assign oflow_o    = oflow_q;
  assign nonempty_o = active && (head_q != tail_q);

  // R4
  state_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q));
  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && active && full && !clr_of_i && !dis_i)
      |=> (oflow_q && state_q == ST_ERROR && $stable(tail_q)));
  // R7
  tail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok_o |=> $stable(tail_q));
  // R7
  tail_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_q <= LAST);
endmodule

// File: rtl/msi_eq_writer.sv
module msi_eq_writer
  import msi_eq_pkg::*;
#(
  parameter int NUM_MSI    = 32,
  parameter int NUM_EQ     = 4,
  parameter int EQ_ENTRIES = 8,
  parameter int IDX_W      = 8,
  localparam int MSI_W = (NUM_MSI > 1) ? $clog2(NUM_MSI) : 1,
  localparam int EQ_W  = (NUM_EQ > 1) ? $clog2(NUM_EQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msi_valid_i,
  input  logic              msi_is64_i,
  input  logic [15:0]       msi_rid_i,
  input  logic [63:0]       msi_addr_i,
  input  logic [31:0]       msi_data_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              eq_wr_valid_o,
  output logic [EQ_W-1:0]   eq_wr_queue_o,
  output logic [PTR_W-1:0]  eq_wr_slot_o,
  output logic [63:0]       eq_wr_word0_o,
  output logic [63:0]       eq_wr_word1_o,
  output logic [NUM_EQ-1:0] eq_nonempty_o
);
  map_ent_t         ents [NUM_MSI];
  map_ent_t         ent;
  logic [15:0]      msi_num;
  logic [MSI_W-1:0] msi_idx;
  logic             go, any_ok;
  logic             idx_msi_ok, idx_eq_ok;
  logic [EQ_W-1:0]  ok_q;
  logic [NUM_EQ-1:0] push, wr_ok, set_en, dis, clr_of, head_we;
  eq_state_e        q_state [NUM_EQ];
  logic [PTR_W-1:0] q_head [NUM_EQ];
  logic [PTR_W-1:0] q_tail [NUM_EQ];
  logic             q_oflow [NUM_EQ];

  assign msi_num    = msi_data_i[15:0];
  assign msi_idx    = msi_num[MSI_W-1:0];
  assign ent        = ents[msi_idx];
  assign go         = msi_valid_i && (msi_num < 16'(NUM_MSI)) && ent.valid && !ent.pend
                      && (ent.eq < QNUM_W'(NUM_EQ));
  assign idx_msi_ok = reg_idx_i < IDX_W'(NUM_MSI);
  assign idx_eq_ok  = reg_idx_i < IDX_W'(NUM_EQ);

  msi_map_table #(.NUM_MSI(NUM_MSI)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_pend_i (any_ok),
    .set_idx_i  (msi_idx),
    .cfg_we_i   (reg_we_i && reg_sel_i == RS_MAP && idx_msi_ok),
    .cfg_idx_i  (reg_idx_i[MSI_W-1:0]),
    .cfg_valid_i(reg_wdata_i[BIT_VALID]),
    .cfg_eq_i   (reg_wdata_i[QNUM_W-1:0]),
    .clr_we_i   (reg_we_i && reg_sel_i == RS_MSICLR && idx_msi_ok && reg_wdata_i[BIT_PEND]),
    .clr_idx_i  (reg_idx_i[MSI_W-1:0]),
    .ents_o     (ents)
  );

  for (genvar q = 0; q < NUM_EQ; q++) begin : g_q
    logic sel_q;
    assign sel_q      = reg_we_i && idx_eq_ok && reg_idx_i == IDX_W'(q);
    assign push[q]    = go && ent.eq == QNUM_W'(q);
    assign set_en[q]  = sel_q && reg_sel_i == RS_CSET && reg_wdata_i[BIT_EN];
    assign dis[q]     = sel_q && reg_sel_i == RS_CCLR && reg_wdata_i[BIT_EN];
    assign clr_of[q]  = sel_q && reg_sel_i == RS_CCLR && reg_wdata_i[BIT_OFLOW];
    assign head_we[q] = sel_q && reg_sel_i == RS_HEAD;

    msi_eq_queue #(.EQ_ENTRIES(EQ_ENTRIES)) u_q (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (push[q]),
      .set_en_i  (set_en[q]),
      .dis_i     (dis[q]),
      .clr_of_i  (clr_of[q]),
      .head_we_i (head_we[q]),
      .head_i    (reg_wdata_i[PTR_W-1:0]),
      .wr_ok_o   (wr_ok[q]),
      .state_o   (q_state[q]),
      .head_o    (q_head[q]),
      .tail_o    (q_tail[q]),
      .oflow_o   (q_oflow[q]),
      .nonempty_o(eq_nonempty_o[q])
    );
  end

  assign any_ok = |wr_ok;

  always_comb begin
    ok_q = '0;
    for (int q = 0; q < NUM_EQ; q++) if (wr_ok[q]) ok_q = EQ_W'(q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_wr_valid_o <= 1'b0;
      eq_wr_queue_o <= '0;
      eq_wr_slot_o  <= '0;
      eq_wr_word0_o <= '0;
      eq_wr_word1_o <= '0;
    end else begin
      eq_wr_valid_o <= any_ok;
      if (any_ok) begin
        eq_wr_queue_o <= ok_q;
        eq_wr_slot_o  <= q_tail[ok_q];
        eq_wr_word0_o <= mk_word0(msi_is64_i, msi_rid_i, msi_addr_i, msi_data_i);
        eq_wr_word1_o <= mk_word1(msi_addr_i, msi_data_i);
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      RS_MAP: if (idx_msi_ok) begin
        reg_rdata_o[BIT_VALID]    = ents[reg_idx_i[MSI_W-1:0]].valid;
        reg_rdata_o[BIT_PEND]     = ents[reg_idx_i[MSI_W-1:0]].pend;
        reg_rdata_o[QNUM_W-1:0]   = ents[reg_idx_i[MSI_W-1:0]].eq;
      end
      RS_STATE: if (idx_eq_ok) reg_rdata_o[2:0] = q_state[reg_idx_i[EQ_W-1:0]];
      RS_TAIL: if (idx_eq_ok) begin
        reg_rdata_o[BIT_OFLOW]  = q_oflow[reg_idx_i[EQ_W-1:0]];
        reg_rdata_o[PTR_W-1:0]  = q_tail[reg_idx_i[EQ_W-1:0]];
      end
      RS_HEAD: if (idx_eq_ok) reg_rdata_o[PTR_W-1:0] = q_head[reg_idx_i[EQ_W-1:0]];
      default: reg_rdata_o = '0;
    endcase
  end

  // R5
  word0_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_wr_valid_o |-> (!eq_wr_word0_o[63] && eq_wr_word0_o[62:56] != 7'd0));
  // R7
  wr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_wr_valid_o |-> $past(msi_valid_i));
  // R3
  one_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_ok));
endmodule

// File: tb/msi_eq_writer_tb_top.sv
module msi_eq_writer_tb_top;
  localparam int NUM_MSI = 32;
  localparam int NUM_EQ  = 4;
  localparam int ENT     = 8;
  localparam int IDX_W   = 8;

  typedef struct {
    int          q;
    int          slot;
    logic [63:0] w0;
    logic [63:0] w1;
  } rec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msi_valid = 0, msi_is64 = 0;
  logic [15:0] msi_rid = '0;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic reg_we = 0;
  logic [2:0] reg_sel = '0;
  logic [IDX_W-1:0] reg_idx = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic wr_valid;
  logic [1:0] wr_queue;
  logic [6:0] wr_slot;
  logic [63:0] wr_w0, wr_w1;
  logic [NUM_EQ-1:0] nonempty;

  int errors = 0, checks = 0;
  bit done = 0;
  rec_t sb[$];

  // reference model
  bit mv [NUM_MSI], mp [NUM_MSI];
  int me [NUM_MSI];
  int qs [NUM_EQ], qh [NUM_EQ], qt [NUM_EQ];
  bit qof [NUM_EQ];

  always #5 clk = ~clk;

  msi_eq_writer #(.NUM_MSI(NUM_MSI), .NUM_EQ(NUM_EQ), .EQ_ENTRIES(ENT), .IDX_W(IDX_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .msi_valid_i(msi_valid), .msi_is64_i(msi_is64), .msi_rid_i(msi_rid),
    .msi_addr_i(msi_addr), .msi_data_i(msi_data),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .eq_wr_valid_o(wr_valid), .eq_wr_queue_o(wr_queue), .eq_wr_slot_o(wr_slot),
    .eq_wr_word0_o(wr_w0), .eq_wr_word1_o(wr_w1), .eq_nonempty_o(nonempty)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R2/R3/R4/R8 unexpected write", {57'd0, wr_slot}, 64'd0);
      end else begin
        rec_t e;
        e = sb.pop_front();
        chk(wr_queue == 2'(e.q) && wr_slot == 7'(e.slot), "R7 queue/slot",
            {48'd0, 6'd0, wr_queue, 1'b0, wr_slot}, {48'd0, 6'd0, 2'(e.q), 1'b0, 7'(e.slot)});
        chk(wr_w0 == e.w0, "R5 word0", wr_w0, e.w0);
        chk(wr_w1 == e.w1, "R6 word1", wr_w1, e.w1);
      end
    end
  end

  task automatic reg_wr(input int sel, input int idx, input logic [63:0] wd);
    reg_sel = 3'(sel); reg_idx = IDX_W'(idx); reg_wdata = wd; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
    case (sel)
      0: if (idx < NUM_MSI) begin mv[idx] = wd[63]; me[idx] = int'(wd[5:0]); end
      1: if (idx < NUM_MSI && wd[62]) mp[idx] = 0;
      2: if (idx < NUM_EQ && wd[44] && qs[idx] == 1) qs[idx] = 2;
      3: if (idx < NUM_EQ) begin
           if (wd[44]) qs[idx] = 1;
           if (wd[57]) begin qof[idx] = 0; if (qs[idx] == 4) qs[idx] = 1; end
         end
      6: if (idx < NUM_EQ) qh[idx] = int'(wd[6:0]);
      default: ;
    endcase
  endtask

  task automatic reg_rd(input int sel, input int idx, output logic [63:0] rd);
    reg_sel = 3'(sel); reg_idx = IDX_W'(idx);
    #1 rd = reg_rdata;
  endtask

  task automatic send(input logic [31:0] data, input bit is64, input logic [15:0] rid,
                      input logic [63:0] addr);
    int n, q, nx;
    n = int'(data[15:0]);
    if (n < NUM_MSI && mv[n] && !mp[n] && me[n] < NUM_EQ && qs[me[n]] == 2) begin
      q = me[n];
      nx = (qt[q] == ENT - 1) ? 0 : qt[q] + 1;
      if (nx == qh[q]) begin
        qof[q] = 1; qs[q] = 4;
      end else begin
        rec_t r;
        r.q = q; r.slot = qt[q];
        r.w0 = {1'b0, (is64 ? 7'h78 : 7'h58), 10'd1, addr[15:2], rid, data[15:0]};
        r.w1 = {addr[63:16], data[31:16]};
        sb.push_back(r);
        qt[q] = nx; mp[n] = 1;
      end
    end
    msi_data = data; msi_is64 = is64; msi_rid = rid; msi_addr = addr; msi_valid = 1;
    @(negedge clk);
    msi_valid = 0;
    @(negedge clk);
  endtask

  task automatic check_q(input int q, input string tag);
    logic [63:0] rd;
    reg_rd(4, q, rd);
    chk(rd == 64'(qs[q]), {tag, " R4 state"}, rd, 64'(qs[q]));
    reg_rd(5, q, rd);
    chk(rd == ({6'd0, qof[q], 57'd0} | 64'(qt[q])), {tag, " R7/R8 tail"}, rd,
        {6'd0, qof[q], 57'd0} | 64'(qt[q]));
    reg_rd(6, q, rd);
    chk(rd == 64'(qh[q]), {tag, " R9 head"}, rd, 64'(qh[q]));
    chk(nonempty[q] == (qs[q] == 2 && qh[q] != qt[q]), {tag, " R9 nonempty"},
        64'(nonempty[q]), 64'(qs[q] == 2 && qh[q] != qt[q]));
  endtask

  task automatic check_map(input int n, input string tag);
    logic [63:0] rd, ex;
    reg_rd(0, n, rd);
    ex = {mv[n], mp[n], 56'd0, 6'(me[n])};
    chk(rd == ex, {tag, " R2/R3 map"}, rd, ex);
  endtask

  initial begin
    logic [63:0] en, dis, clr_of, clr_pend;
    en = 64'd1 << 44; dis = 64'd1 << 44; clr_of = 64'd1 << 57; clr_pend = 64'd1 << 62;
    for (int i = 0; i < NUM_MSI; i++) begin mv[i] = 0; mp[i] = 0; me[i] = 0; end
    for (int q = 0; q < NUM_EQ; q++) begin qs[q] = 1; qh[q] = 0; qt[q] = 0; qof[q] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int q = 0; q < NUM_EQ; q++) check_q(q, "R1");
    check_map(3, "R1");
    chk(nonempty == '0, "R1 nonempty", 64'(nonempty), 64'd0);

    // R2 unmapped MSI dropped
    send(32'd3, 0, 16'h1111, 64'h0000_0000_FEE0_0010);
    check_q(1, "R2");

    // map 3->q1, queue disabled: dropped (R4)
    reg_wr(0, 3, {1'b1, 57'd0, 6'd1});
    check_map(3, "R2");
    send(32'd3, 0, 16'h1111, 64'h0000_0000_FEE0_0010);
    check_q(1, "R4 disabled");

    // enable q1, 32-bit MSI accepted (R5/R6/R7)
    reg_wr(2, 1, en);
    check_q(1, "R4 enabled");
    send(32'hABCD_0003, 0, 16'h0102, 64'h0000_0000_FEE0_1234);
    check_q(1, "R7");
    check_map(3, "R3 pend set");

    // R3 pending blocks
    send(32'h0000_0003, 1, 16'h0102, 64'h1234_5678_9ABC_DEF0);
    check_q(1, "R3 blocked");

    // R3 clear without bit 62 has no effect
    reg_wr(1, 3, 64'd0);
    check_map(3, "R3 noclear");
    reg_wr(1, 3, clr_pend);
    check_map(3, "R3 clear");
    send(32'h5555_0003, 1, 16'hBEEF, 64'h1234_5678_9ABC_DEF0);
    check_q(1, "R7 second");

    // R2 out-of-range MSI number and target queue
    send(32'h0000_0040, 0, 16'h1, 64'h10);
    reg_wr(0, 5, {1'b1, 57'd0, 6'd9});
    send(32'h0000_0005, 0, 16'h1, 64'h10);
    check_q(1, "R2 range");

    // R9 head advance empties queue
    reg_wr(6, 1, 64'd2);
    check_q(1, "R9 head");

    // R7 wrap on q1: MSIs 20..25 -> tail 2..7,0
    for (int i = 20; i < 26; i++) reg_wr(0, i, {1'b1, 57'd0, 6'd1});
    for (int i = 20; i < 26; i++) send(32'(i) | 32'h0007_0000, i[0], 16'(i), 64'hFFFF_0000_0000_0000 | 64'(i << 4));
    check_q(1, "R7 wrap");

    // R8 overflow on q0: head 0, MSIs 10..17
    reg_wr(2, 0, en);
    for (int i = 10; i < 18; i++) reg_wr(0, i, {1'b1, 57'd0, 6'd0});
    for (int i = 10; i < 18; i++) send(32'(i), 0, 16'h00AA, 64'h0000_0000_0000_1000);
    check_q(0, "R8 overflow");
    check_map(17, "R8 no pend");
    // further MSI dropped in error
    reg_wr(0, 18, {1'b1, 57'd0, 6'd0});
    send(32'd18, 0, 16'h00AA, 64'h0);
    check_q(0, "R8 error drop");
    // clear overflow -> idle, re-enable, free space
    reg_wr(3, 0, clr_of);
    check_q(0, "R8 clear");
    reg_wr(2, 0, en);
    reg_wr(6, 0, 64'd3);
    send(32'd18, 1, 16'h00AB, 64'hAAAA_BBBB_CCCC_DDDD);
    check_q(0, "R8 resume");

    // R4 disable
    reg_wr(3, 0, dis);
    check_q(0, "R4 disable");
    send(32'd17, 0, 16'h1, 64'h0);
    check_q(0, "R4 drop after disable");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R7 missing writes", 64'(sb.size()), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule